// File: doc/BRIEF.md
# Ethernet receive acceptance filter

This block watches a received frame one byte per beat and decides, when the last byte arrives, whether the frame should be kept. It takes the first six bytes as the destination address. It compares that address with a small table of station addresses, and it sorts the address into one of three kinds: individual, group, or all-ones. It then applies the receive controls, the length limits and the error policy.

Each frame produces a one-cycle result. The result carries the keep/drop verdict and the length that will be delivered, with or without the trailing 4-byte check sequence. It also carries a flag set on kept frames that matched no table entry. Software reads that flag to know it must inspect such a frame itself.

The frame stream has a byte, a valid strobe, first-byte and last-byte markers, and an error flag that is sampled with the last byte. The controls and the table are static inputs. They are sampled on the last byte of each frame.

Top module: `rx_accept_filter`

## Requirements
- R1: `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that takes a byte with `in_valid` and `in_eof` both high. `dec_accept` and `dec_no_exact` are low whenever `dec_valid` is low, and all three are low after reset.
- R2: While `ctl_rx_en` is low on the last byte, the frame is dropped whatever the other controls say.
- R3: The destination is the first six bytes of the frame. Byte k of the frame is compared with bits [8k+7:8k] of a table entry, and entry e occupies `stn_addr[48e+47:48e]`. A frame whose destination equals an entry with its `stn_valid` bit set is kept with `dec_no_exact` = 0. Entries whose valid bit is clear never match.
- R4: A destination with bit 0 of its first byte equal to 0 is individual. If it matches no valid entry, it is kept only when `ctl_uc_promisc` is set, and then with `dec_no_exact` = 1.
- R5: A destination with bit 0 of its first byte equal to 1 that is not all-ones is a group address. If it matches no valid entry, it is kept only when `ctl_mc_promisc` is set, and then with `dec_no_exact` = 1. `ctl_uc_promisc` does not admit it.
- R6: The all-ones destination, when it matches no valid entry, is kept only when `ctl_bcast_acc` is set, and then with `dec_no_exact` = 1. Neither promiscuous control admits it.
- R7: The frame length counts every byte, including the 4 check bytes. Frames shorter than 64 bytes are dropped, and a 64-byte frame is kept.
- R8: Frames longer than 1522 bytes are dropped unless `ctl_long_en` is set. A 1522-byte frame is kept with `ctl_long_en` clear.
- R9: A frame with `in_crc_err` high on its last byte is dropped unless `ctl_store_bad` is set.
- R10: On a kept frame, `dec_len` is the counted length, or the counted length minus 4 when `ctl_strip_crc` is set.
- R11: `dec_no_exact` is 0 on every dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_crc_err | input | 1 | Check-sequence error, sampled with the last byte |
| ctl_rx_en | input | 1 | Reception allowed |
| ctl_store_bad | input | 1 | Keep frames flagged with an error |
| ctl_uc_promisc | input | 1 | Keep every individual-address frame |
| ctl_mc_promisc | input | 1 | Keep every group-address frame |
| ctl_bcast_acc | input | 1 | Keep all-ones-address frames |
| ctl_long_en | input | 1 | Allow frames above 1522 bytes |
| ctl_strip_crc | input | 1 | Exclude the 4 check bytes from the delivered length |
| stn_addr | input | NUM_ENT*48 | Station address table, entry e at bits [48e+47:48e] |
| stn_valid | input | NUM_ENT | Valid bit per table entry |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Frame is kept |
| dec_no_exact | output | 1 | Kept frame matched no table entry |
| dec_len | output | LEN_W | Delivered length in bytes |

## Verification
Every result of this block is due in one place: the cycle after the edge that takes the last byte of the frame. The verdict, the flag and the length appear together in that cycle, and the strobe falls one cycle later. The bench drives each byte on the falling clock edge. It reads the verdict at the falling edge right after the last byte has been taken, and it checks that the strobe has dropped at the next falling edge. Length corners (63, 64, 1522 and 1523 bytes) and each address kind are run as separate frames with the controls set before the first byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int CRC_BYTES  = 4;
    localparam int MIN_FRAME  = 64;
    localparam int MAX_FRAME  = 1522;

    typedef logic [8*ADDR_BYTES-1:0] mac_t;

    typedef enum logic [1:0] {
        KIND_UNICAST   = 2'd0,
        KIND_MULTICAST = 2'd1,
        KIND_BROADCAST = 2'd2
    } addr_kind_e;

    typedef struct packed {
        logic rx_en;
        logic store_bad;
        logic uc_promisc;
        logic mc_promisc;
        logic bcast_acc;
        logic long_en;
        logic strip_crc;
    } rx_ctl_t;

    // Group bit is bit 0 of the first byte on the wire.
    function automatic addr_kind_e classify(input mac_t a);
        if (&a)
            return KIND_BROADCAST;
        else if (a[0])
            return KIND_MULTICAST;
        else
            return KIND_UNICAST;
    endfunction

endpackage

// File: rtl/rxf_frame_track.sv
module rxf_frame_track
    import rxf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output mac_t             dst,
    output logic [LEN_W-1:0] frame_len,
    output logic             end_beat
);

    localparam logic [LEN_W-1:0] LEN_SAT = '1;

    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] pos;

    assign pos       = in_sof ? '0 : cnt;
    assign frame_len = (pos == LEN_SAT) ? LEN_SAT : pos + 1'b1;
    assign end_beat  = in_valid && in_eof;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            dst <= '0;
        end else if (in_valid) begin
            cnt <= frame_len;
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (pos == LEN_W'(k))
                    dst[8*k +: 8] <= in_data;
            end
        end
    end

endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
    import rxf_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  mac_t                  dst,
    input  logic [NUM_ENT*48-1:0] tbl_addr,
    input  logic [NUM_ENT-1:0]    tbl_valid,
    output logic                  hit
);

    logic [NUM_ENT-1:0] hits;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        assign hits[e] = tbl_valid[e] && (tbl_addr[48*e +: 48] == dst);
    end

    assign hit = |hits;

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = MIN_FRAME,
    parameter int MAX_LEN = MAX_FRAME
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             end_beat,
    input  logic [LEN_W-1:0] frame_len,
    input  addr_kind_e       kind,
    input  logic             exact_hit,
    input  logic             crc_err,
    input  rx_ctl_t          ctl,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_no_exact,
    output logic [LEN_W-1:0] dec_len
);

    localparam logic [LEN_W-1:0] LMIN = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LMAX = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LCRC = LEN_W'(CRC_BYTES);

    logic             mode_ok;
    logic             addr_ok;
    logic             len_ok;
    logic             err_ok;
    logic             accept;
    logic [LEN_W-1:0] len_out;

    always_comb begin
        case (kind)
            KIND_UNICAST:   mode_ok = ctl.uc_promisc;
            KIND_MULTICAST: mode_ok = ctl.mc_promisc;
            KIND_BROADCAST: mode_ok = ctl.bcast_acc;
            default:        mode_ok = 1'b0;
        endcase
    end

    assign addr_ok = exact_hit || mode_ok;
    assign len_ok  = (frame_len >= LMIN) && ((frame_len <= LMAX) || ctl.long_en);
    assign err_ok  = !crc_err || ctl.store_bad;
    assign accept  = ctl.rx_en && addr_ok && len_ok && err_ok;
    assign len_out = (ctl.strip_crc && frame_len >= LCRC) ? frame_len - LCRC : frame_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid    <= 1'b0;
            dec_accept   <= 1'b0;
            dec_no_exact <= 1'b0;
            dec_len      <= '0;
        end else begin
            dec_valid    <= end_beat;
            dec_accept   <= end_beat && accept;
            dec_no_exact <= end_beat && accept && !exact_hit;
            if (end_beat)
                dec_len <= len_out;
        end
    end

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
    import rxf_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = MIN_FRAME,
    parameter int MAX_LEN = MAX_FRAME
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  in_sof,
    input  logic                  in_eof,
    input  logic                  in_crc_err,
    input  logic                  ctl_rx_en,
    input  logic                  ctl_store_bad,
    input  logic                  ctl_uc_promisc,
    input  logic                  ctl_mc_promisc,
    input  logic                  ctl_bcast_acc,
    input  logic                  ctl_long_en,
    input  logic                  ctl_strip_crc,
    input  logic [NUM_ENT*48-1:0] stn_addr,
    input  logic [NUM_ENT-1:0]    stn_valid,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output logic                  dec_no_exact,
    output logic [LEN_W-1:0]      dec_len
);

    mac_t             dst;
    logic [LEN_W-1:0] frame_len;
    logic             end_beat;
    logic             exact_hit;
    addr_kind_e       kind;
    rx_ctl_t          ctl;

    assign ctl = '{rx_en:      ctl_rx_en,
                   store_bad:  ctl_store_bad,
                   uc_promisc: ctl_uc_promisc,
                   mc_promisc: ctl_mc_promisc,
                   bcast_acc:  ctl_bcast_acc,
                   long_en:    ctl_long_en,
                   strip_crc:  ctl_strip_crc};

    assign kind = classify(dst);

    rxf_frame_track #(.LEN_W(LEN_W)) track_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .dst       (dst),
        .frame_len (frame_len),
        .end_beat  (end_beat)
    );

    rxf_addr_match #(.NUM_ENT(NUM_ENT)) match_i (
        .dst       (dst),
        .tbl_addr  (stn_addr),
        .tbl_valid (stn_valid),
        .hit       (exact_hit)
    );

    rxf_decide #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN)
    ) decide_i (
        .clk          (clk),
        .rst          (rst),
        .end_beat     (end_beat),
        .frame_len    (frame_len),
        .kind         (kind),
        .exact_hit    (exact_hit),
        .crc_err      (in_crc_err),
        .ctl          (ctl),
        .dec_valid    (dec_valid),
        .dec_accept   (dec_accept),
        .dec_no_exact (dec_no_exact),
        .dec_len      (dec_len)
    );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1522
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_eof,
    input logic             in_crc_err,
    input logic             ctl_rx_en,
    input logic             ctl_store_bad,
    input logic             ctl_long_en,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic             dec_no_exact,
    input logic [LEN_W-1:0] dec_len
);

    localparam logic [LEN_W-1:0] KEPT_MIN = LEN_W'(MIN_LEN - 4);
    localparam logic [LEN_W-1:0] KEPT_MAX = LEN_W'(MAX_LEN);

    assert_strobe_after_last_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof) |=> dec_valid);

    assert_strobe_only_after_last_R1: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(in_valid && in_eof));

    assert_quiet_without_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!dec_accept && !dec_no_exact));

    assert_disabled_drops_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof && !ctl_rx_en) |=> !dec_accept);

    assert_kept_not_runt_R7: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> (dec_len >= KEPT_MIN));

    assert_long_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof && !ctl_long_en) |=> (!dec_accept || dec_len <= KEPT_MAX));

    assert_bad_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof && in_crc_err && !ctl_store_bad) |=> !dec_accept);

    assert_flag_needs_keep_R11: assert property (@(posedge clk) disable iff (rst)
        dec_no_exact |-> dec_accept);

endmodule

bind rx_accept_filter rxf_checker #(
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_eof        (in_eof),
    .in_crc_err    (in_crc_err),
    .ctl_rx_en     (ctl_rx_en),
    .ctl_store_bad (ctl_store_bad),
    .ctl_long_en   (ctl_long_en),
    .dec_valid     (dec_valid),
    .dec_accept    (dec_accept),
    .dec_no_exact  (dec_no_exact),
    .dec_len       (dec_len)
);

// File: tb/rx_accept_filter_tb_top.sv
`timescale 1ns/1ps
module rx_accept_filter_tb_top;

    localparam int NUM_ENT = 4;
    localparam int LEN_W   = 16;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic [7:0]            in_data = '0;
    logic                  in_sof = 1'b0;
    logic                  in_eof = 1'b0;
    logic                  in_crc_err = 1'b0;
    logic                  ctl_rx_en, ctl_store_bad, ctl_uc_promisc, ctl_mc_promisc;
    logic                  ctl_bcast_acc, ctl_long_en, ctl_strip_crc;
    logic [NUM_ENT*48-1:0] stn_addr;
    logic [NUM_ENT-1:0]    stn_valid;
    logic                  dec_valid, dec_accept, dec_no_exact;
    logic [LEN_W-1:0]      dec_len;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rx_accept_filter #(.NUM_ENT(NUM_ENT), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_crc_err(in_crc_err),
        .ctl_rx_en(ctl_rx_en), .ctl_store_bad(ctl_store_bad),
        .ctl_uc_promisc(ctl_uc_promisc), .ctl_mc_promisc(ctl_mc_promisc),
        .ctl_bcast_acc(ctl_bcast_acc), .ctl_long_en(ctl_long_en),
        .ctl_strip_crc(ctl_strip_crc), .stn_addr(stn_addr), .stn_valid(stn_valid),
        .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_no_exact(dec_no_exact), .dec_len(dec_len)
    );

    // Byte 0 (first on the wire) lands in bits [7:0].
    function automatic logic [47:0] mac(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    localparam logic [47:0] STN0  = 48'h5544_3322_1102;  // 02:11:22:33:44:55
    localparam logic [47:0] STN1  = 48'h0504_0302_AA02;  // invalid entry
    localparam logic [47:0] STN2  = 48'h0100_005E_0001;  // group 01:00:5e:00:00:01
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic defaults();
        ctl_rx_en = 1; ctl_store_bad = 0; ctl_uc_promisc = 0; ctl_mc_promisc = 0;
        ctl_bcast_acc = 0; ctl_long_en = 0; ctl_strip_crc = 0;
    endtask

    task automatic run_frame(input string req, input logic [47:0] dst, input int len,
                             input bit crc, input bit exp_acc, input bit exp_pif);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_sof     = (i == 0);
            in_eof     = (i == len - 1);
            in_data    = (i < 6) ? dst[8*i +: 8] : 8'(i);
            in_crc_err = crc && (i == len - 1);
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_crc_err = 0;
        chk(req, "strobe", int'(dec_valid), 1);
        chk(req, "accept", int'(dec_accept), int'(exp_acc));
        chk(req, "no_exact", int'(dec_no_exact), int'(exp_pif));
        if (exp_acc)
            chk(req, "length", int'(dec_len), ctl_strip_crc ? len - 4 : len);
        @(negedge clk);
        chk("R1", "strobe drops", int'(dec_valid), 0);
    endtask

    task automatic test_reset();
        chk("R1", "reset strobe", int'(dec_valid), 0);
        chk("R1", "reset accept", int'(dec_accept), 0);
        chk("R1", "reset flag", int'(dec_no_exact), 0);
    endtask

    task automatic test_exact();
        defaults();
        run_frame("R3", STN0, 64, 0, 1, 0);
        run_frame("R3", STN1, 64, 0, 0, 0);   // invalid entry, R11 flag stays 0
        run_frame("R3", STN2, 70, 0, 1, 0);   // group address held in the table
    endtask

    task automatic test_unicast();
        defaults();
        run_frame("R4", mac(8'h02, 8'h99, 8'h88, 8'h77, 8'h66, 8'h55), 80, 0, 0, 0);
        ctl_uc_promisc = 1;
        run_frame("R4", mac(8'h02, 8'h99, 8'h88, 8'h77, 8'h66, 8'h55), 80, 0, 1, 1);
        run_frame("R4", STN1, 64, 0, 1, 1);
    endtask

    task automatic test_multicast();
        defaults();
        ctl_uc_promisc = 1;
        run_frame("R5", mac(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h07), 72, 0, 0, 0);
        ctl_mc_promisc = 1;
        run_frame("R5", mac(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h07), 72, 0, 1, 1);
    endtask

    task automatic test_broadcast();
        defaults();
        ctl_uc_promisc = 1; ctl_mc_promisc = 1;
        run_frame("R6", BCAST, 64, 0, 0, 0);
        defaults();
        ctl_bcast_acc = 1;
        run_frame("R6", BCAST, 64, 0, 1, 1);
    endtask

    task automatic test_length();
        defaults();
        run_frame("R7", STN0, 63, 0, 0, 0);
        run_frame("R7", STN0, 10, 0, 0, 0);
        run_frame("R8", STN0, 1522, 0, 1, 0);
        run_frame("R8", STN0, 1523, 0, 0, 0);
        ctl_long_en = 1;
        run_frame("R8", STN0, 1600, 0, 1, 0);
    endtask

    task automatic test_crc_err();
        defaults();
        run_frame("R9", STN0, 100, 1, 0, 0);
        ctl_store_bad = 1;
        run_frame("R9", STN0, 100, 1, 1, 0);
    endtask

    task automatic test_strip();
        defaults();
        ctl_strip_crc = 1;
        run_frame("R10", STN0, 96, 0, 1, 0);
        ctl_uc_promisc = 1;
        run_frame("R10", mac(8'h06, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 64, 0, 1, 1);
    endtask

    task automatic test_rx_enable();
        defaults();
        ctl_rx_en = 0; ctl_uc_promisc = 1; ctl_bcast_acc = 1;
        run_frame("R2", STN0, 64, 0, 0, 0);
        run_frame("R2", BCAST, 64, 0, 0, 0);
        ctl_rx_en = 1;
        run_frame("R2", STN0, 64, 0, 1, 0);
    endtask

    initial begin
        defaults();
        stn_addr  = {48'h0, STN2, STN1, STN0};
        stn_valid = 4'b0101;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        test_exact();
        test_unicast();
        test_multicast();
        test_broadcast();
        test_length();
        test_crc_err();
        test_strip();
        test_rx_enable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule